// File: doc/BRIEF.md
# Byte-Region Nibble-Fold Checksum Engine

This block computes a 16-bit checksum over a run of bytes in a small byte-wide memory. It then stores the result back into that memory. A controller supplies a start address, a byte length and a destination address, and pulses a start strobe. The engine reads the region through a single read/write port that returns data one cycle after the read request. It folds the bytes into the checksum and writes the two result bytes to the destination, most significant byte first. It then pulses a completion flag and holds the result on an output.

The checksum starts at 0xFFFF. For each update, take the running value p and a 16-bit input v, and let d = p ^ v, a = d[3:0] and b = d[7:4] ^ a. The new value is (p >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12), kept to 16 bits. The inputs are big-endian words taken at every byte offset below the length rounded down to even, so the words overlap by one byte. An odd length adds one final update that places the next byte in the upper half with a zero low half. Each byte is fetched from memory only once, because the low byte of one word is kept as the high byte of the next. A typical use checksums the first 0xF8 bytes of a configuration header and writes the result at offset 0xFC.

The controller has seven states. IDLE waits for start. HEAD captures the first byte. STEP folds one word per cycle. TAIL folds the odd last byte. WR_HI and WR_LO store the result. FIN signals completion. The transitions are:
- IDLE→HEAD on start with a non-zero length.
- IDLE→WR_HI on start with a zero length.
- HEAD→STEP when at least one word remains, and HEAD→TAIL when none does.
- STEP→STEP while more than one word remains.
- STEP→TAIL on the last word of an odd length, and STEP→WR_HI on the last word of an even length.
- TAIL→WR_HI, then WR_HI→WR_LO, WR_LO→FIN and FIN→IDLE.

Top module: `nvck_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd` and `mem_wr` are low and `sum` reads 0xFFFF.
- R2: Every update applies the nibble-fold rule above to a running value that starts at 0xFFFF on each accepted start.
- R3: For a length L, the engine folds the words {byte[base+i], byte[base+i+1]} for i = 0 up to (L rounded down to even) − 1, in increasing i. Addresses wrap modulo the address space.
- R4: When L is odd, one last update uses {byte[base+E], 8'h00}, where E is L rounded down to even.
- R5: A length of zero performs no memory read and produces 0xFFFF.
- R6: The result's bits [15:8] are written to `dest`, and then bits [7:0] are written to `dest`+1 in the next cycle.
- R7: `done` is high for exactly one cycle. That cycle immediately follows the write of the low result byte, and `busy` is low in it and afterwards.
- R8: A start pulse that arrives while `busy` is high is ignored. It causes no extra run, no extra memory access and no change of result.
- R9: Each byte is read once, in increasing address order starting at `base`. A run of length L issues 0 reads for L = 0, L+1 reads for even L > 0, and L reads for odd L. A read and a write never occur in the same cycle.
- R10: `sum` keeps its value while the engine is idle and no start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_start | input | 1 | One-cycle start strobe, accepted only when idle |
| in_base | input | AW | First byte address of the region |
| in_len | input | CW | Region length in bytes |
| in_dest | input | AW | Address where the result high byte goes |
| mem_addr | output | AW | Memory address for read or write |
| mem_rd | output | 1 | Read request; data valid on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| sum | output | 16 | Checksum of the latest run |

## Verification
On every cycle, the embedded assertions check the port-level protocol. They check that reads and writes are exclusive, that `done` is a single-cycle pulse directly after a write, and that reads happen only while busy or on an accepted start. They also check that a zero-length start is followed by a write rather than a read, that the word counter never underflows, and that `sum` is stable while idle. Only the bench's scenarios can show the checksum value itself. The bench sweeps many bases and lengths, including wrap at the top of the address space and the header-sized region, and compares against an arithmetic model. It also checks the exact read count and order, the placement of the stored bytes, and that a start during a run has no effect.

// File: rtl/nvck_pkg.sv
package nvck_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_STEP,
        ST_TAIL,
        ST_WR_HI,
        ST_WR_LO,
        ST_FIN
    } nvck_state_e;

    localparam logic [15:0] NVCK_SEED = 16'hFFFF;

endpackage

// File: rtl/nvck_fold.sv
module nvck_fold (
    input  logic [15:0] i_prev,
    input  logic [15:0] i_word,
    output logic [15:0] o_next
);
    logic [15:0] mix;
    logic [3:0]  nib_a;
    logic [3:0]  nib_b;
    logic [15:0] ext_a;
    logic [15:0] ext_b;

    always_comb begin
        mix    = i_prev ^ i_word;
        nib_a  = mix[3:0];
        nib_b  = mix[7:4] ^ nib_a;
        ext_a  = {12'd0, nib_a};
        ext_b  = {12'd0, nib_b};
        o_next = (i_prev >> 8)
               ^ (ext_a << 3) ^ (ext_a << 8)
               ^ ext_b ^ (ext_b << 7) ^ (ext_b << 12);
    end
endmodule

// File: rtl/nvck_ptr.sv
module nvck_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_load,
    input  logic [AW-1:0] i_load_val,
    input  logic          i_adv,
    output logic [AW-1:0] o_ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_ptr <= '0;
        end else if (i_load) begin
            o_ptr <= i_load_val;
        end else if (i_adv) begin
            o_ptr <= o_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/nvck_steps.sv
module nvck_steps #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_load,
    input  logic [CW-1:0] i_count,
    input  logic          i_dec,
    output logic          o_none,
    output logic          o_last
);
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (i_load) begin
            left_q <= i_count;
        end else if (i_dec) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign o_none = (left_q == '0);
    assign o_last = (left_q == CW'(1));

    // R9: the word counter is never decremented past zero
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        i_dec |-> !o_none);
endmodule

// File: rtl/nvck_engine.sv
module nvck_engine
    import nvck_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_start,
    input  logic [AW-1:0] in_base,
    input  logic [CW-1:0] in_len,
    input  logic [AW-1:0] in_dest,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [15:0]   sum
);
    nvck_state_e   state_q, state_d;
    logic [15:0]   crc_q;
    logic [7:0]    hi_q;
    logic          odd_q;
    logic [AW-1:0] dest_q;
    logic          accept;
    logic [CW-1:0] len_even;
    logic [AW-1:0] ptr;
    logic          steps_none, steps_last;
    logic          step_dec;
    logic [15:0]   fold_word, fold_out;

    assign accept   = (state_q == ST_IDLE) && in_start;
    assign len_even = {in_len[CW-1:1], 1'b0};
    assign step_dec = (state_q == ST_STEP);

    nvck_ptr #(.AW(AW)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_load     (accept),
        .i_load_val (in_base + 1'b1),
        .i_adv      (mem_rd && (state_q != ST_IDLE)),
        .o_ptr      (ptr)
    );

    nvck_steps #(.CW(CW)) u_steps (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_load  (accept),
        .i_count (len_even),
        .i_dec   (step_dec),
        .o_none  (steps_none),
        .o_last  (steps_last)
    );

    assign fold_word = (state_q == ST_TAIL) ? {hi_q, 8'h00} : {hi_q, mem_rdata};

    nvck_fold u_fold (
        .i_prev (crc_q),
        .i_word (fold_word),
        .o_next (fold_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_start) state_d = (in_len == '0) ? ST_WR_HI : ST_HEAD;
            ST_HEAD:  state_d = steps_none ? ST_TAIL : ST_STEP;
            ST_STEP:  if (steps_last) state_d = odd_q ? ST_TAIL : ST_WR_HI;
            ST_TAIL:  state_d = ST_WR_HI;
            ST_WR_HI: state_d = ST_WR_LO;
            ST_WR_LO: state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_addr  = ptr;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = 8'h00;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                mem_addr = in_base;
                mem_rd   = in_start && (in_len != '0);
            end
            ST_HEAD:  mem_rd = !steps_none;
            ST_STEP:  mem_rd = !steps_last;
            ST_TAIL:  mem_rd = 1'b0;
            ST_WR_HI: begin
                mem_wr    = 1'b1;
                mem_addr  = dest_q;
                mem_wdata = crc_q[15:8];
            end
            ST_WR_LO: begin
                mem_wr    = 1'b1;
                mem_addr  = dest_q + 1'b1;
                mem_wdata = crc_q[7:0];
            end
            ST_FIN: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q  <= NVCK_SEED;
            hi_q   <= 8'h00;
            odd_q  <= 1'b0;
            dest_q <= '0;
        end else begin
            if (accept) begin
                crc_q  <= NVCK_SEED;
                odd_q  <= in_len[0];
                dest_q <= in_dest;
            end
            if (state_q == ST_HEAD) hi_q <= mem_rdata;
            if (state_q == ST_STEP) begin
                crc_q <= fold_out;
                hi_q  <= mem_rdata;
            end
            if (state_q == ST_TAIL) crc_q <= fold_out;
        end
    end

    assign sum = crc_q;

    // R9: one port, never read and write together
    p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R9: reads only during a run or on the cycle a start is accepted
    p_rd_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !busy) |-> in_start);
    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: completion directly follows a write, with busy low
    p_done_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_wr) && !busy));
    // R5: zero-length start goes straight to writing, no read
    p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && in_start && in_len == '0) |=> (mem_wr && !mem_rd));
    // R10: result held while idle without a start
    p_sum_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !in_start) |=> $stable(sum));
endmodule

// File: tb/nvck_engine_test.sv
module nvck_engine_test;
    localparam int AW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_start = 1'b0;
    logic [AW-1:0] in_base = '0;
    logic [CW-1:0] in_len = '0;
    logic [AW-1:0] in_dest = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          busy, done;
    logic [15:0]   sum;

    logic [7:0]    mem [256];
    logic          tb_we = 1'b0;
    logic [7:0]    tb_wa = '0;
    logic [7:0]    tb_wd = '0;

    int            total = 0;
    int            bad = 0;
    int            cyc = 0;
    int            rd_total = 0;
    int            wr_total = 0;
    logic [7:0]    rd_log [1024];

    always #5 clk = ~clk;

    nvck_engine #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .in_start(in_start), .in_base(in_base),
        .in_len(in_len), .in_dest(in_dest), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .sum(sum)
    );

    // memory model: one-cycle read latency, plus a bench fill port
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr];
            rd_log[rd_total % 1024] <= mem_addr;
            rd_total <= rd_total + 1;
        end
        if (mem_wr) begin
            mem[mem_addr] <= mem_wdata;
            wr_total <= wr_total + 1;
        end
        if (tb_we) mem[tb_wa] <= tb_wd;
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: got cycle %0d exp below 150000", cyc);
            $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    function automatic logic [15:0] ref_fold(input logic [15:0] p, input logic [15:0] v);
        int d, a, b, r;
        d = int'(p ^ v);
        a = d % 16;
        b = ((d / 16) % 16) ^ a;
        r = (int'(p) / 256) ^ (a * 8) ^ (a * 256) ^ b ^ (b * 128) ^ (b * 4096);
        return r[15:0];
    endfunction

    function automatic logic [15:0] ref_sum(input int base, input int len);
        logic [15:0] c;
        int ev;
        c  = 16'hFFFF;
        ev = (len / 2) * 2;
        for (int i = 0; i < ev; i++)
            c = ref_fold(c, {mem[(base + i) % 256], mem[(base + i + 1) % 256]});
        if (len % 2 == 1)
            c = ref_fold(c, {mem[(base + ev) % 256], 8'h00});
        return c;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            tb_we = 1'b1;
            tb_wa = 8'(i);
            tb_wd = 8'((i * 29 + seed) ^ (i / 8));
        end
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic poke(input int a, input int d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = 8'(a); tb_wd = 8'(d);
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic wait_done(output int ok);
        int n;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        ok = done ? 1 : 0;
    endtask

    task automatic run_case(input int base, input int len, input int dest);
        logic [15:0] exp;
        int r0, nrd, ord_bad, ok, exp_rd;
        exp = ref_sum(base, len);
        r0  = rd_total;
        @(negedge clk);
        in_base = 8'(base); in_len = 8'(len); in_dest = 8'(dest); in_start = 1'b1;
        @(negedge clk);
        in_start = 1'b0;
        wait_done(ok);
        chk("R7 done reached", ok, 1);
        chk((len == 0) ? "R5 zero length sum" : ((len % 2) ? "R4 odd tail sum" : "R2 R3 sum"),
            int'(sum), int'(exp));
        chk("R6 high byte at dest", int'(mem[dest % 256]), int'(exp[15:8]));
        chk("R6 low byte at dest+1", int'(mem[(dest + 1) % 256]), int'(exp[7:0]));
        nrd = rd_total - r0;
        exp_rd = (len == 0) ? 0 : ((len % 2 == 0) ? len + 1 : len);
        chk("R9 read count", nrd, exp_rd);
        ord_bad = 0;
        for (int k = 0; k < nrd; k++)
            if (rd_log[(r0 + k) % 1024] != 8'(base + k)) ord_bad++;
        chk("R9 read order", ord_bad, 0);
        chk("R7 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk("R7 done one cycle", int'(done), 0);
        @(negedge clk);
        @(negedge clk);
        chk("R10 sum held idle", int'(sum), int'(exp));
    endtask

    initial begin
        int starts [4] = '{0, 17, 100, 250};
        int ok, r0, w0;
        logic [15:0] exp;

        fill(7);
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 no access after reset", int'(mem_rd | mem_wr), 0);
        chk("R1 sum after reset", int'(sum), 16'hFFFF);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of bases and lengths, including wrap past address 255
        foreach (starts[s])
            for (int len = 0; len < 22; len++)
                run_case(starts[s], len, starts[s] + 40);

        // header-sized region
        fill(91);
        run_case(0, 248, 252);

        // R8: start while busy is ignored
        poke(144, 8'h5A);
        poke(145, 8'hA5);
        exp = ref_sum(0, 10);
        r0 = rd_total;
        w0 = wr_total;
        @(negedge clk);
        in_base = 8'd0; in_len = 8'd10; in_dest = 8'd128; in_start = 1'b1;
        @(negedge clk);
        in_start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 engine busy before second start", int'(busy), 1);
        in_base = 8'd48; in_len = 8'd0; in_dest = 8'd144; in_start = 1'b1;
        @(negedge clk);
        in_start = 1'b0;
        wait_done(ok);
        chk("R8 first run completes", ok, 1);
        chk("R8 result unaffected", int'(sum), int'(exp));
        repeat (6) @(negedge clk);
        chk("R8 no second run", int'(busy), 0);
        chk("R8 dest untouched hi", int'(mem[144]), 8'h5A);
        chk("R8 dest untouched lo", int'(mem[145]), 8'hA5);
        chk("R8 reads of one run only", rd_total - r0, 11);
        chk("R8 writes of one run only", wr_total - w0, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule